// File: doc/BRIEF.md
# MMU Fault Entry Capture

This block records processor state at the moment the address-translation unit reports a fault, and redirects execution to the fault handler. It handles two fault kinds: an access that violates an entry's protection, and an access that matches a selected entry whose valid bit is clear. In the same clock edge as the fault strobe, it loads a set of capture registers:

- the page-number part of the faulting address;
- the full faulting address;
- an exception code chosen from the fault kind and the access direction;
- the resume PC;
- a copy of the pre-fault status word;
- the updated status word;
- the way that produced the fault.

One cycle later it raises a single-cycle redirect strobe carrying the handler address, which is the vector base plus 0x100. The resume PC is rewound to the delayed branch when the faulting instruction sits in a delay slot.

The surrounding core supplies the current status word on every cycle. A fault strobe that arrives while the block bit of that word is already set is dropped, so a nested fault cannot overwrite the saved state of the first one.

Top module: `mmu_fault_entry`

## Requirements
- R1: On an accepted fault, page_tag_o receives vaddr_i with its low PAGE_BITS (default 10) bits cleared, and fault_addr_o receives vaddr_i unchanged.
- R2: On an accepted fault, exc_code_o takes one of four values. For fault_kind_i=1 (protection) it is 0x0A0 on a load and 0x0C0 on a store. For fault_kind_i=0 (invalid entry) it is 0x040 on a load and 0x060 on a store. A store is store_i=1.
- R3: On an accepted fault, saved_pc_o receives pc_i when delay_slot_i=0, and branch_pc_i when delay_slot_i=1.
- R4: On an accepted fault, saved_sr_o receives the value cur_sr_i had in the strobe cycle.
- R5: On an accepted fault, sr_o equals cur_sr_i with three bits forced to 1: bit 30 (privileged mode), bit 29 (register bank) and bit 28 (block). All other bits are unchanged. This holds for both fault kinds.
- R6: On an accepted fault, fault_way_o receives way_i.
- R7: All capture registers commit at the clock edge that ends the strobe cycle. redirect_o is 1 for exactly the one following cycle. During that cycle redirect_pc_o equals vec_base_i + 0x100, taking vec_base_i as sampled in the strobe cycle.
- R8: A fault strobe with cur_sr_i bit 28 set is ignored: no output changes and redirect_o stays 0.
- R9: After reset, sr_o equals SR_RESET (default 0x7000_0000). Every other output is 0.
- R10: With fault_i low, every capture output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fault_i | input | 1 | Fault strobe from the translation unit |
| fault_kind_i | input | 1 | 1 = protection violation, 0 = invalid entry |
| store_i | input | 1 | 1 = store access, 0 = load access |
| vaddr_i | input | ADDR_W | Faulting virtual address |
| way_i | input | WAY_W | Way that produced the fault |
| pc_i | input | ADDR_W | Address of the current instruction |
| delay_slot_i | input | 1 | Current instruction is in a delay slot |
| branch_pc_i | input | ADDR_W | Address of the associated delayed branch |
| cur_sr_i | input | SR_W | Current status word |
| vec_base_i | input | ADDR_W | Vector base |
| page_tag_o | output | ADDR_W | Captured page-number field |
| fault_addr_o | output | ADDR_W | Captured full faulting address |
| exc_code_o | output | CODE_W | Captured exception code |
| saved_pc_o | output | ADDR_W | Resume PC |
| saved_sr_o | output | SR_W | Pre-fault status word |
| sr_o | output | SR_W | Status word after entry |
| fault_way_o | output | WAY_W | Captured way number |
| redirect_o | output | 1 | One-cycle handler redirect strobe |
| redirect_pc_o | output | ADDR_W | Handler address |

## Verification
Some internal faults are visible at the ports one cycle after the strobe. A wrong accept decision shows either as changed capture registers after a strobe that should have been dropped, or as a missing redirect pulse. A wrong code selection, or a wrong PC multiplexer setting, leaves a mismatched value in the same cycle that redirect_o rises. A stuck redirect register, or a status word whose forced bits are wrong, is visible by the second cycle after the strobe. The sweep covers every combination of kind, direction, delay slot and way, and then repeats strobes with the block bit set to confirm that nothing moves.

// File: rtl/mfe_pkg.sv
package mfe_pkg;
  localparam int CODE_W = 12;
  localparam logic [31:0] VEC_OFFSET = 32'h0000_0100;

  // Exception code from fault kind (1 = protection) and direction (1 = store).
  function automatic logic [CODE_W-1:0] entry_code(input logic prot, input logic store);
    logic [CODE_W-1:0] c;
    case ({prot, store})
      2'b00:   c = 12'h040;
      2'b01:   c = 12'h060;
      2'b10:   c = 12'h0A0;
      default: c = 12'h0C0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/mfe_classify.sv
module mfe_classify
  import mfe_pkg::*;
#(
  parameter int SR_W    = 32,
  parameter int BLK_BIT = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_i,
  input  logic              prot_i,
  input  logic              store_i,
  input  logic [SR_W-1:0]   cur_sr_i,
  output logic              accept_o,
  output logic              blocked_o,
  output logic [CODE_W-1:0] code_o
);
  assign blocked_o = cur_sr_i[BLK_BIT];
  assign accept_o  = fault_i & ~blocked_o;
  assign code_o    = entry_code(prot_i, store_i);

  // R2: only the four defined codes can ever be produced
  a_r2_code_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == 12'h040) || (code_o == 12'h060) || (code_o == 12'h0A0) || (code_o == 12'h0C0));
endmodule

// File: rtl/mfe_status.sv
module mfe_status #(
  parameter int              SR_W     = 32,
  parameter int              PC_W     = 32,
  parameter int              PRIV_BIT = 30,
  parameter int              BANK_BIT = 29,
  parameter int              BLK_BIT  = 28,
  parameter logic [SR_W-1:0] SR_RESET = 32'h7000_0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            accept_i,
  input  logic [SR_W-1:0] cur_sr_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] branch_pc_i,
  input  logic            delay_slot_i,
  output logic [SR_W-1:0] saved_sr_o,
  output logic [SR_W-1:0] sr_o,
  output logic [PC_W-1:0] saved_pc_o
);
  localparam logic [SR_W-1:0] ENTRY_SET =
    (SR_W'(1) << PRIV_BIT) | (SR_W'(1) << BANK_BIT) | (SR_W'(1) << BLK_BIT);

  logic [SR_W-1:0] sr_next;
  logic [PC_W-1:0] resume_pc;

  assign sr_next   = cur_sr_i | ENTRY_SET;
  assign resume_pc = delay_slot_i ? branch_pc_i : pc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      saved_sr_o <= '0;
      sr_o       <= SR_RESET;
      saved_pc_o <= '0;
    end else if (accept_i) begin
      saved_sr_o <= cur_sr_i;
      sr_o       <= sr_next;
      saved_pc_o <= resume_pc;
    end
  end

  // R4: saved word is the pre-fault status
  a_r4_saved_sr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> saved_sr_o == $past(cur_sr_i));
  // R5: entry bits set after capture
  a_r5_entry_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> (sr_o[PRIV_BIT] && sr_o[BANK_BIT] && sr_o[BLK_BIT]));
  // R3: resume PC chosen from delay-slot flag
  a_r3_resume_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && delay_slot_i) |=> saved_pc_o == $past(branch_pc_i));
  // R10: no strobe, no change
  a_r10_sr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(sr_o) && $stable(saved_sr_o) && $stable(saved_pc_o));
endmodule

// File: rtl/mfe_capture.sv
module mfe_capture
  import mfe_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 10,
  parameter int WAY_W     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic [WAY_W-1:0]  way_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [ADDR_W-1:0] vec_base_i,
  output logic [ADDR_W-1:0] page_tag_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic [CODE_W-1:0] exc_code_o,
  output logic [WAY_W-1:0]  fault_way_o,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_pc_o
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << PAGE_BITS) - ADDR_W'(1));

  logic [ADDR_W-1:0] page_next;
  logic [ADDR_W-1:0] target_next;

  assign page_next   = vaddr_i & PAGE_MASK;
  assign target_next = vec_base_i + ADDR_W'(VEC_OFFSET);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_tag_o    <= '0;
      fault_addr_o  <= '0;
      exc_code_o    <= '0;
      fault_way_o   <= '0;
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
    end else begin
      redirect_o <= accept_i;
      if (accept_i) begin
        page_tag_o    <= page_next;
        fault_addr_o  <= vaddr_i;
        exc_code_o    <= code_i;
        fault_way_o   <= way_i;
        redirect_pc_o <= target_next;
      end
    end
  end

  // R7: pulse only follows an accepted strobe
  a_r7_pulse_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> $past(accept_i));
  // R1: low page bits of captured tag are zero
  a_r1_tag_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page_tag_o & ~PAGE_MASK) == '0);
  // R6: way register follows input on capture
  a_r6_way: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> fault_way_o == $past(way_i));
endmodule

// File: rtl/mmu_fault_entry.sv
module mmu_fault_entry
  import mfe_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              SR_W      = 32,
  parameter int              WAY_W     = 2,
  parameter int              PAGE_BITS = 10,
  parameter int              PRIV_BIT  = 30,
  parameter int              BANK_BIT  = 29,
  parameter int              BLK_BIT   = 28,
  parameter logic [SR_W-1:0] SR_RESET  = 32'h7000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_i,
  input  logic              fault_kind_i,
  input  logic              store_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic [WAY_W-1:0]  way_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              delay_slot_i,
  input  logic [ADDR_W-1:0] branch_pc_i,
  input  logic [SR_W-1:0]   cur_sr_i,
  input  logic [ADDR_W-1:0] vec_base_i,
  output logic [ADDR_W-1:0] page_tag_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic [CODE_W-1:0] exc_code_o,
  output logic [ADDR_W-1:0] saved_pc_o,
  output logic [SR_W-1:0]   saved_sr_o,
  output logic [SR_W-1:0]   sr_o,
  output logic [WAY_W-1:0]  fault_way_o,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_pc_o
);
  logic              accept;
  logic              blocked;
  logic [CODE_W-1:0] code_next;

  mfe_classify #(.SR_W(SR_W), .BLK_BIT(BLK_BIT)) u_classify (
    .clk_i(clk_i), .rst_ni(rst_ni), .fault_i(fault_i), .prot_i(fault_kind_i),
    .store_i(store_i), .cur_sr_i(cur_sr_i), .accept_o(accept),
    .blocked_o(blocked), .code_o(code_next)
  );

  mfe_status #(
    .SR_W(SR_W), .PC_W(ADDR_W), .PRIV_BIT(PRIV_BIT), .BANK_BIT(BANK_BIT),
    .BLK_BIT(BLK_BIT), .SR_RESET(SR_RESET)
  ) u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept), .cur_sr_i(cur_sr_i),
    .pc_i(pc_i), .branch_pc_i(branch_pc_i), .delay_slot_i(delay_slot_i),
    .saved_sr_o(saved_sr_o), .sr_o(sr_o), .saved_pc_o(saved_pc_o)
  );

  mfe_capture #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .WAY_W(WAY_W)) u_capture (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept), .vaddr_i(vaddr_i),
    .way_i(way_i), .code_i(code_next), .vec_base_i(vec_base_i),
    .page_tag_o(page_tag_o), .fault_addr_o(fault_addr_o), .exc_code_o(exc_code_o),
    .fault_way_o(fault_way_o), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
  );

  // R8: a strobe while blocked leaves state and redirect untouched
  a_r8_blocked_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && blocked) |=> !redirect_o && $stable(saved_sr_o) && $stable(exc_code_o));
  // R7: the pulse never lasts two cycles without a fresh strobe
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && !accept) |=> !redirect_o);
endmodule

// File: tb/test_mmu_fault_entry.sv
module test_mmu_fault_entry;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        fault = 0, kind = 0, store = 0, dslot = 0;
  logic [31:0] vaddr = 0, pc = 0, bpc = 0, cur_sr = 0, vbase = 0;
  logic [1:0]  way = 0;
  logic [31:0] page_tag, fault_addr, saved_pc, saved_sr, sr, redir_pc;
  logic [11:0] code;
  logic [1:0]  fway;
  logic        redir;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_fault_entry i_mmu_fault_entry (
    .clk_i(clk), .rst_ni(rst_n), .fault_i(fault), .fault_kind_i(kind), .store_i(store),
    .vaddr_i(vaddr), .way_i(way), .pc_i(pc), .delay_slot_i(dslot), .branch_pc_i(bpc),
    .cur_sr_i(cur_sr), .vec_base_i(vbase), .page_tag_o(page_tag), .fault_addr_o(fault_addr),
    .exc_code_o(code), .saved_pc_o(saved_pc), .saved_sr_o(saved_sr), .sr_o(sr),
    .fault_way_o(fway), .redirect_o(redir), .redirect_pc_o(redir_pc)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] e_tag, e_addr, e_pc, e_ssr, e_sr, e_rpc;
    logic [11:0] e_code;
    logic [1:0]  e_way;
    repeat (3) @(negedge clk);
    // R9 reset values
    chk("R9 sr", sr, 32'h7000_0000);
    chk("R9 saved_sr", saved_sr, 0);
    chk("R9 code", {20'd0, code}, 0);
    chk("R9 redirect", {31'd0, redir}, 0);
    rst_n = 1;
    @(negedge clk);
    for (int n = 0; n < 32; n++) begin
      kind  = n[0]; store = n[1]; dslot = n[2]; way = n[4:3];
      vaddr = 32'h1357_9BDF * (n + 1) + 32'h0000_03FF * n;
      pc    = 32'h8000_0000 + 32'd2 * n;
      bpc   = pc - 32'd2;
      cur_sr = (32'h0A5A_5A5A ^ (32'h0110_0301 * n)) & ~(32'h1 << 28);
      vbase = 32'hA000_0000 + (n << 12);
      fault = 1;
      e_tag  = (vaddr >> 10) << 10;
      e_addr = vaddr;
      e_code = 12'd64 + 12'd96 * kind + 12'd32 * store;
      e_pc   = dslot ? bpc : pc;
      e_ssr  = cur_sr;
      e_sr   = cur_sr | 32'h4000_0000 | 32'h2000_0000 | 32'h1000_0000;
      e_way  = way;
      e_rpc  = vbase + 256;
      @(negedge clk);
      fault = 0;
      cur_sr = 32'hFFFF_0000; vaddr = 0; vbase = 0; // disturb inputs
      chk("R7 redirect high", {31'd0, redir}, 1);
      chk("R7 redirect pc", redir_pc, e_rpc);
      chk("R1 page tag", page_tag, e_tag);
      chk("R1 fault addr", fault_addr, e_addr);
      chk("R2 code", {20'd0, code}, {20'd0, e_code});
      chk("R3 saved pc", saved_pc, e_pc);
      chk("R4 saved sr", saved_sr, e_ssr);
      chk("R5 sr", sr, e_sr);
      chk("R6 way", {30'd0, fway}, {30'd0, e_way});
      @(negedge clk);
      chk("R7 redirect single", {31'd0, redir}, 0);
      chk("R10 hold addr", fault_addr, e_addr);
      chk("R10 hold sr", sr, e_sr);
      // R8 blocked strobe is ignored
      if (n % 4 == 0) begin
        cur_sr = 32'h1000_0000 | (n << 2);
        fault = 1; vaddr = ~e_addr; way = ~e_way; kind = ~kind; store = ~store;
        pc = 32'h1234_5678; dslot = 0; vbase = 32'h5555_0000;
        @(negedge clk);
        fault = 0;
        chk("R8 no redirect", {31'd0, redir}, 0);
        chk("R8 addr held", fault_addr, e_addr);
        chk("R8 code held", {20'd0, code}, {20'd0, e_code});
        chk("R8 saved sr held", saved_sr, e_ssr);
        chk("R8 sr held", sr, e_sr);
        chk("R8 pc held", saved_pc, e_pc);
        chk("R8 way held", {30'd0, fway}, {30'd0, e_way});
        @(negedge clk);
        chk("R8 still no redirect", {31'd0, redir}, 0);
      end
    end
    finish_run();
  end
endmodule